// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor and returns a 32-bit quotient. The dividend is assembled from two 32-bit words: a dedicated high word supplies the upper half, and operand A supplies the lower half. Operand B is the divisor. A mode input selects unsigned or two's-complement signed division. Signed division works on magnitudes and then fixes the sign, so results truncate toward zero.

A zero divisor ends the operation at once with a trap indication and no quotient. A quotient that does not fit in 32 bits is clamped to the nearest 32-bit limit for the selected mode, and an overflow bit is raised. A second mode input asks for a flag update. When it is set, the final quotient and the overflow bit are written into a small condition state that stays visible on the outputs.

Requests enter on a valid/ready pair. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the result is delivered, and a valid request offered while ready is low is not taken and has no effect. The result side has no back-pressure. `done` is high for exactly one cycle, and `quotient`, `ovf` and `dz_trap` are valid in that cycle.

Top module: `wide_sat_divider`

## Requirements
- R1: The dividend is `hi_word` in bits 63:32 and `opnd_a` in bits 31:0. The divisor is `opnd_b`. In unsigned mode (`req_signed`=0), a quotient of at most 0xFFFFFFFF is returned exactly with `ovf`=0.
- R2: If `opnd_b` is 0, the result cycle shows `dz_trap`=1, `quotient`=0 and `ovf`=0, and `cc_quot`/`cc_ovf` keep their previous values even when `req_setcc`=1. For a nonzero divisor, `dz_trap`=0.
- R3: In unsigned mode, a quotient above 0xFFFFFFFF is returned as 0xFFFFFFFF with `ovf`=1.
- R4: In signed mode, a dividend of 0x8000000000000000 divided by 0xFFFFFFFF (-1) returns 0x7FFFFFFF with `ovf`=1.
- R5: In signed mode, a quotient above 2^31-1 returns 0x7FFFFFFF with `ovf`=1, and a quotient below -2^31 returns 0x80000000 with `ovf`=1.
- R6: In signed mode, a quotient that fits in signed 32 bits is returned exactly, rounded toward zero, with `ovf`=0. This includes exactly -2^31.
- R7: When `req_setcc`=1 and the divisor is nonzero, `cc_quot` and `cc_ovf` take the returned quotient and overflow bit, visible in the `done` cycle. When `req_setcc`=0, they are unchanged.
- R8: For a nonzero divisor, `done` rises 65 clock edges after the accepting edge (2*W+1 for width W). For a zero divisor, it rises on the next edge.
- R9: `req_ready` is low from the edge after acceptance until `done` is shown. A request offered in that window is ignored, and the result belongs to the accepted request.
- R10: `done` is high for exactly one cycle per accepted request.
- R11: After reset, `req_ready`=1, `done`=0, `cc_quot`=0 and `cc_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_signed | input | 1 | 1 = signed division, 0 = unsigned |
| req_setcc | input | 1 | 1 = write the result into the condition state |
| hi_word | input | 32 | Upper dividend word |
| opnd_a | input | 32 | Lower dividend word |
| opnd_b | input | 32 | Divisor |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Clamped quotient |
| ovf | output | 1 | Quotient was clamped |
| dz_trap | output | 1 | Divisor was zero |
| cc_quot | output | 32 | Condition state: last recorded quotient |
| cc_ovf | output | 1 | Condition state: last recorded overflow |

## Verification
The assertions watch the handshake and strobe rules on every cycle:
- `done` stays high for only one cycle.
- Acceptance drops `req_ready`.
- A trap result is clean and leaves the condition state alone.
- The condition state changes only in a `done` cycle.
- Every unsigned clamp reads all ones.
- The iteration engine starts on load.

The numeric results need the bench's directed scenarios, because they depend on the operand values. These cover exact quotients, the clamp boundaries in each direction, the most-negative-by-minus-one case, rounding toward zero, exact latency, and a request offered while busy that must be ignored.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  typedef struct packed {
    logic is_signed;
    logic setcc;
    logic negate;
  } wsd_ctl_t;
endpackage

// File: rtl/wsd_prep.sv
module wsd_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0]   hi_w,
  input  logic [W-1:0]   lo_w,
  input  logic [W-1:0]   dsr_w,
  input  logic           is_signed,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dsr_mag,
  output logic           negate,
  output logic           dsr_zero
);
  localparam int DW = 2 * W;
  logic [DW-1:0] dvd_raw;
  logic          dvd_neg, dsr_neg;

  always_comb begin
    dvd_raw  = {hi_w, lo_w};
    dvd_neg  = is_signed & dvd_raw[DW-1];
    dsr_neg  = is_signed & dsr_w[W-1];
    dvd_mag  = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
    dsr_mag  = dsr_neg ? (~dsr_w + 1'b1) : dsr_w;
    negate   = dvd_neg ^ dsr_neg;
    dsr_zero = (dsr_w == '0);
  end
endmodule

// File: rtl/wsd_core.sv
module wsd_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] dvd_in,
  input  logic [W-1:0]   dsr_in,
  output logic           fin,
  output logic [2*W-1:0] quo_mag
);
  localparam int ITER = 2 * W;
  localparam int CW   = $clog2(ITER);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  logic [2*W-1:0] dq_q;
  logic [W-1:0]   rem_q;
  logic [W-1:0]   dsr_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q;
  logic [W:0]     shifted;
  logic           ge;
  logic [W:0]     diff;

  always_comb begin
    shifted = {rem_q, dq_q[2*W-1]};
    ge      = (shifted >= {1'b0, dsr_q});
    diff    = shifted - {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_q  <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        dq_q  <= dvd_in;
        rem_q <= '0;
        dsr_q <= dsr_in;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
        dq_q  <= {dq_q[2*W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quo_mag = dq_q;

  // R8
  core_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run_q && !fin);
endmodule

// File: rtl/wsd_sat.sv
module wsd_sat #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] mag,
  input  logic           is_signed,
  input  logic           negate,
  output logic [W-1:0]   q,
  output logic           ovf
);
  localparam logic [2*W-1:0] UMAX = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [2*W-1:0] SPOS = UMAX >> 1;
  localparam logic [2*W-1:0] SNEG = SPOS + 1'b1;

  always_comb begin
    q   = mag[W-1:0];
    ovf = 1'b0;
    if (!is_signed) begin
      if (mag > UMAX) begin
        q   = '1;
        ovf = 1'b1;
      end
    end else if (!negate) begin
      if (mag > SPOS) begin
        q   = {1'b0, {(W-1){1'b1}}};
        ovf = 1'b1;
      end
    end else begin
      if (mag > SNEG) begin
        q   = {1'b1, {(W-1){1'b0}}};
        ovf = 1'b1;
      end else begin
        q = ~mag[W-1:0] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wide_sat_divider.sv
module wide_sat_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_signed,
  input  logic         req_setcc,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         ovf,
  output logic         dz_trap,
  output logic [W-1:0] cc_quot,
  output logic         cc_ovf
);
  import wsd_pkg::*;

  logic           busy_q, zero_q;
  wsd_ctl_t       ctl_q;
  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dsr_mag;
  logic           negate, dsr_zero;
  logic           accept, core_fin;
  logic [2*W-1:0] quo_mag;
  logic [W-1:0]   sat_q;
  logic           sat_ovf;

  assign req_ready = ~busy_q;
  assign accept    = req_valid & ~busy_q;

  wsd_prep #(.W(W)) u_prep (
    .hi_w(hi_word), .lo_w(opnd_a), .dsr_w(opnd_b), .is_signed(req_signed),
    .dvd_mag(dvd_mag), .dsr_mag(dsr_mag), .negate(negate), .dsr_zero(dsr_zero)
  );

  wsd_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept & ~dsr_zero),
    .dvd_in(dvd_mag), .dsr_in(dsr_mag), .fin(core_fin), .quo_mag(quo_mag)
  );

  wsd_sat #(.W(W)) u_sat (
    .mag(quo_mag), .is_signed(ctl_q.is_signed), .negate(ctl_q.negate),
    .q(sat_q), .ovf(sat_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      zero_q   <= 1'b0;
      ctl_q    <= '0;
      done     <= 1'b0;
      quotient <= '0;
      ovf      <= 1'b0;
      dz_trap  <= 1'b0;
      cc_quot  <= '0;
      cc_ovf   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        zero_q <= dsr_zero;
        ctl_q  <= '{is_signed: req_signed, setcc: req_setcc, negate: negate};
      end else if (busy_q && (zero_q || core_fin)) begin
        busy_q <= 1'b0;
        zero_q <= 1'b0;
        done   <= 1'b1;
        if (zero_q) begin
          quotient <= '0;
          ovf      <= 1'b0;
          dz_trap  <= 1'b1;
        end else begin
          quotient <= sat_q;
          ovf      <= sat_ovf;
          dz_trap  <= 1'b0;
          if (ctl_q.setcc) begin
            cc_quot <= sat_q;
            cc_ovf  <= sat_ovf;
          end
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  trap_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_trap) |-> (!ovf && quotient == '0 && $stable(cc_quot) && $stable(cc_ovf)));
  // R7
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cc_quot) && $stable(cc_ovf)));
  // R3
  uclamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf && !ctl_q.is_signed) |-> (quotient == '1));
endmodule

// File: tb/wide_sat_divider_bench.sv
module wide_sat_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_signed = 1'b0, req_setcc = 1'b0;
  logic [31:0] hi_word = '0, opnd_a = '0, opnd_b = '0;
  logic        req_ready, done, ovf, dz_trap, cc_ovf;
  logic [31:0] quotient, cc_quot;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wide_sat_divider u_wide_sat_divider (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_signed(req_signed), .req_setcc(req_setcc), .hi_word(hi_word),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .quotient(quotient),
    .ovf(ovf), .dz_trap(dz_trap), .cc_quot(cc_quot), .cc_ovf(cc_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] hi, a, b, input bit sgn,
                       output logic [31:0] q, output bit o, output bit z);
    logic [63:0] ux, uq;
    longint sx, sq;
    longint sb;
    q = '0; o = 1'b0; z = (b == 0);
    if (z) return;
    ux = {hi, a};
    if (!sgn) begin
      uq = ux / {32'd0, b};
      if (uq > 64'hFFFF_FFFF) begin q = 32'hFFFF_FFFF; o = 1'b1; end
      else q = uq[31:0];
    end else begin
      sx = longint'(ux);
      sb = longint'(signed'(b));
      if (sx == 64'sh8000_0000_0000_0000 && sb == -1) begin q = 32'h7FFF_FFFF; o = 1'b1; end
      else begin
        sq = sx / sb;
        if (sq > 64'sd2147483647) begin q = 32'h7FFF_FFFF; o = 1'b1; end
        else if (sq < -64'sd2147483648) begin q = 32'h8000_0000; o = 1'b1; end
        else q = sq[31:0];
      end
    end
  endtask

  // Issues one request, optionally pokes a rival request while busy, checks all results.
  task automatic do_op(input logic [31:0] hi, a, b, input bit sgn, input bit cc,
                       input string req, input bit poke = 1'b0);
    logic [31:0] eq, cq0;
    bit eo, ez, co0;
    int cyc;
    model(hi, a, b, sgn, eq, eo, ez);
    cq0 = cc_quot; co0 = cc_ovf;
    @(negedge clk);
    chk(req_ready, "R9 ready before request", req_ready, 1);
    hi_word = hi; opnd_a = a; opnd_b = b; req_signed = sgn; req_setcc = cc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    if (!ez) chk(!req_ready, "R9 ready low while busy", req_ready, 0);
    if (poke && !ez) begin
      hi_word = 32'h0; opnd_a = 32'd999; opnd_b = 32'd0; req_signed = 1'b0; req_setcc = 1'b1;
      req_valid = 1'b1;
      @(negedge clk); cyc++;
      req_valid = 1'b0;
    end
    while (!done && cyc < 200) begin
      @(negedge clk); cyc++;
    end
    chk(cyc == (ez ? 1 : 65), {req, " R8 latency"}, cyc, ez ? 1 : 65);
    chk(quotient == eq, {req, " quotient"}, quotient, eq);
    chk(ovf == eo, {req, " overflow"}, ovf, eo);
    chk(dz_trap == ez, {req, " R2 trap"}, dz_trap, ez);
    if (cc && !ez) begin
      chk(cc_quot == eq && cc_ovf == eo, {req, " R7 cc written"}, {cc_ovf, cc_quot}, {eo, eq});
    end else begin
      chk(cc_quot == cq0 && cc_ovf == co0, {req, " R7 cc unchanged"}, {cc_ovf, cc_quot}, {co0, cq0});
    end
    @(negedge clk);
    chk(!done, {req, " R10 single-cycle done"}, done, 0);
    chk(req_ready, {req, " R9 ready after done"}, req_ready, 1);
    if (poke) chk(!done, "R9 ignored request produced no result", done, 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !done && cc_quot == 0 && !cc_ovf, "R11 reset state",
        {req_ready, done, cc_ovf, cc_quot}, {3'b100, 32'd0});
  endtask

  task automatic t_unsigned_fit();
    do_op(32'h0, 32'd100, 32'd7, 1'b0, 1'b0, "R1 100/7");
    do_op(32'h1, 32'h0, 32'd2, 1'b0, 1'b0, "R1 2^32/2");
    do_op(32'h1, 32'hFFFF_FFFE, 32'd2, 1'b0, 1'b0, "R1 exact max");
  endtask

  task automatic t_unsigned_sat();
    do_op(32'h5, 32'h0, 32'd2, 1'b0, 1'b0, "R3 clamp");
    do_op(32'h1, 32'h0, 32'd1, 1'b0, 1'b0, "R3 just above");
  endtask

  task automatic t_zero();
    do_op(32'h1234, 32'h5678, 32'd0, 1'b0, 1'b1, "R2 zero unsigned");
    do_op(32'hFFFF_FFFF, 32'h1, 32'd0, 1'b1, 1'b1, "R2 zero signed");
  endtask

  task automatic t_signed_edge();
    do_op(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 min/-1");
    do_op(32'h1, 32'h0, 32'd1, 1'b1, 1'b0, "R5 positive clamp");
    do_op(32'h1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5 negative clamp");
  endtask

  task automatic t_signed_fit();
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0, "R6 -7/2");
    do_op(32'h0, 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0, "R6 7/-2");
    do_op(32'hFFFF_FFFF, 32'h0, 32'd2, 1'b1, 1'b0, "R6 exact -2^31");
    do_op(32'h0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, "R6 exact max");
  endtask

  task automatic t_setcc();
    do_op(32'h5, 32'h0, 32'd2, 1'b0, 1'b1, "R7 cc clamp");
    do_op(32'h0, 32'd50, 32'd5, 1'b0, 1'b0, "R7 cc kept");
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFF6, 32'd5, 1'b1, 1'b1, "R7 cc signed");
  endtask

  task automatic t_busy_ignore();
    do_op(32'h0, 32'd1000, 32'd10, 1'b0, 1'b0, "R9 busy ignore", 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned_fit();
    t_unsigned_sat();
    t_zero();
    t_signed_edge();
    t_signed_fit();
    t_setcc();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule